// File: doc/BRIEF.md
# Parallel Instruction Length Decoder

This block is the grouping stage at the fetch end of a multi-issue core. The instruction set has two lengths. A plain instruction is one 32-bit word. A long instruction is two words: a prefix word followed by a suffix word. Each cycle the block receives a window of fetched words. The window's address is the fetch PC that the block itself publishes.

Every word in the window gets one of three tags: standalone, prefix or suffix. The tags come from a parallel prefix scan that works like a carry-lookahead adder. The block then forms an ordered issue group, and each instruction in the group carries its own PC. A long instruction always closes the group.

The next fetch PC moves forward by exactly the bytes the group used. Words left over after a closing long instruction are therefore fetched again on the next cycle. A prefix sitting in the last word of the window is left for the next window. A redirect input with a target address throws away the held group and restarts fetch at that target. The published group uses a valid/ready handshake.

Top module: `ild_grouper`

## Requirements
- R1: A word is treated as a prefix when its bits [31:26] equal 6'd1 and it begins an instruction. The word after a prefix is always a suffix, whatever its opcode bits say. The per-word tags appear on `grp_cls` at bits [2i+1:2i] for window word i, coded as 0 standalone, 1 prefix, 2 suffix.
- R2: Every word in the window is tagged, including words after the end of the group. A run of prefix-opcode words alternates prefix, suffix, prefix, suffix.
- R3: Slot i of the group is `grp_insn[64i+63:64i]`. Its low half holds the first word of the instruction. Its high half holds the suffix for a long instruction and zero otherwise. `grp_mask` marks valid slots, is contiguous from slot 0, and invalid slots read zero.
- R4: Slot i carries the PC `grp_pc[PCW*i +: PCW]`, equal to the window base plus 4*i.
- R5: The first long instruction in the window is the last valid slot. Its bit is the only one set in `grp_is64`.
- R6: When a window is taken, `fetch_pc` advances by 4 times the number of words consumed. Those words are all words up to and including the closing suffix, or every word if there is no prefix. A prefix in the last window word is not emitted, and fetch resumes at its address.
- R7: While `grp_valid` is high and `grp_ready` is low, the group and `fetch_pc` hold unchanged, and the window is not taken.
- R8: A redirect clears `grp_valid` on the next edge and loads `fetch_pc` with `redirect_pc`. It takes priority over the handshake and over the window.
- R9: Reset leaves `grp_valid` low and `fetch_pc` at `RESET_PC`.
- R10: When the stage may load but `win_valid` is low, `grp_valid` falls and `fetch_pc` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Window words are present |
| win_words | input | NW*32 | Window words, word i at [32i+31:32i], fetched at `fetch_pc` |
| redirect | input | 1 | Flush and restart fetch |
| redirect_pc | input | PCW | Restart address |
| grp_ready | input | 1 | Consumer takes the group |
| fetch_pc | output | PCW | Address of the window to supply |
| grp_valid | output | 1 | Group is valid |
| grp_mask | output | NW | Valid slots |
| grp_is64 | output | NW | Slot holds a long instruction |
| grp_insn | output | NW*64 | Slot instructions |
| grp_pc | output | NW*PCW | Slot PCs |
| grp_cls | output | NW*2 | Per-word tags of the captured window |

## Verification
Windows of plain words only check full-width issue and the largest PC step. A prefix placed at each word position shows where the group is cut and how far the PC moves. A prefix in the last word tells a held-back prefix apart from an emitted one. A run made only of prefix-opcode words, and a prefix followed by a prefix-opcode suffix, show whether the scan alternates correctly or wrongly tests a suffix as a prefix. Long random streams mix all of these with stalls, empty windows and redirects. A cycle model then separates correct hold and flush ordering from off-by-one PC updates.

// File: rtl/ild_pkg.sv
package ild_pkg;

   localparam int WORD_W  = 32;
   localparam int OPC_LSB = 26;
   localparam int OPC_W   = 6;

   typedef enum logic [1:0] {
      CLS_WORD   = 2'd0,
      CLS_PREFIX = 2'd1,
      CLS_SUFFIX = 2'd2
   } wcls_e;

   // A word's effect on the "next word is a suffix" state, as a map:
   // bit 0 = result when the incoming state is "start", bit 1 = when "suffix".
   function automatic logic [1:0] map_chain(input logic [1:0] first,
                                            input logic [1:0] second);
      return {second[first[1]], second[first[0]]};
   endfunction

endpackage

// File: rtl/ild_scan.sv
module ild_scan
   import ild_pkg::*;
#(
   parameter int         NW        = 4,
   parameter bit         LOOKAHEAD = 1'b1,
   parameter logic [5:0] PFX_OPC   = 6'd1
) (
   input  logic [NW*OPC_W-1:0] opc,
   output logic [2*NW-1:0]     cls
);
   localparam int LV = (NW > 1) ? $clog2(NW) : 1;

   logic [NW-1:0] opc_hit;
   logic [NW-1:0] sfx_in;

   for (genvar i = 0; i < NW; i++) begin : g_hit
      assign opc_hit[i] = (opc[OPC_W*i +: OPC_W] == PFX_OPC);
   end

   if (LOOKAHEAD) begin : g_ks
      // Kogge-Stone style scan over state-transfer maps
      logic [1:0] fmap [0:LV][0:NW-1];
      for (genvar i = 0; i < NW; i++) begin : g_leaf
         assign fmap[0][i] = {1'b0, opc_hit[i]};
      end
      for (genvar l = 0; l < LV; l++) begin : g_lvl
         for (genvar i = 0; i < NW; i++) begin : g_node
            if (i >= (1 << l)) begin : g_join
               assign fmap[l+1][i] = map_chain(fmap[l][i-(1<<l)], fmap[l][i]);
            end else begin : g_pass
               assign fmap[l+1][i] = fmap[l][i];
            end
         end
      end
      assign sfx_in[0] = 1'b0;
      for (genvar i = 1; i < NW; i++) begin : g_state
         assign sfx_in[i] = fmap[LV][i-1][0];
      end
   end else begin : g_ripple
      always_comb begin
         logic st;
         st = 1'b0;
         for (int i = 0; i < NW; i++) begin
            sfx_in[i] = st;
            st        = !st && opc_hit[i];
         end
      end
   end

   for (genvar i = 0; i < NW; i++) begin : g_cls
      assign cls[2*i +: 2] = sfx_in[i]  ? CLS_SUFFIX :
                             opc_hit[i] ? CLS_PREFIX : CLS_WORD;
   end

endmodule

// File: rtl/ild_pick.sv
module ild_pick
   import ild_pkg::*;
#(
   parameter int NW = 4,
   localparam int CW = $clog2(NW + 1)
) (
   input  logic [2*NW-1:0] cls,
   output logic [NW-1:0]   mask,
   output logic [NW-1:0]   is64,
   output logic [CW-1:0]   used
);
   always_comb begin
      logic done;
      done = 1'b0;
      mask = '0;
      is64 = '0;
      used = '0;
      for (int i = 0; i < NW; i++) begin
         if (!done) begin
            if (cls[2*i +: 2] == CLS_PREFIX) begin
               done = 1'b1;
               if (i < NW - 1) begin
                  mask[i] = 1'b1;
                  is64[i] = 1'b1;
                  used    = CW'(i + 2);
               end else begin
                  used    = CW'(i);
               end
            end else begin
               mask[i] = 1'b1;
               used    = CW'(i + 1);
            end
         end
      end
   end
endmodule

// File: rtl/ild_stage.sv
module ild_stage
   import ild_pkg::*;
#(
   parameter int          NW       = 4,
   parameter int          PCW      = 32,
   parameter logic [63:0] RESET_PC = 64'h0,
   localparam int CW = $clog2(NW + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_valid,
   input  logic [NW*32-1:0]    win_words,
   input  logic                redirect,
   input  logic [PCW-1:0]      redirect_pc,
   input  logic                grp_ready,
   input  logic [NW-1:0]       nx_mask,
   input  logic [NW-1:0]       nx_is64,
   input  logic [CW-1:0]       nx_used,
   input  logic [2*NW-1:0]     nx_cls,
   output logic [PCW-1:0]      fetch_pc,
   output logic                grp_valid,
   output logic [NW-1:0]       grp_mask,
   output logic [NW-1:0]       grp_is64,
   output logic [NW*64-1:0]    grp_insn,
   output logic [NW*PCW-1:0]   grp_pc,
   output logic [2*NW-1:0]     grp_cls
);
   logic               take;
   logic [NW*64-1:0]   nx_insn;
   logic [NW*PCW-1:0]  nx_pc;

   assign take = win_valid && (!grp_valid || grp_ready) && !redirect;

   for (genvar i = 0; i < NW; i++) begin : g_slot
      logic [31:0] hi;
      if (i < NW - 1) begin : g_hi
         assign hi = nx_is64[i] ? win_words[32*(i+1) +: 32] : 32'h0;
      end else begin : g_last
         assign hi = 32'h0;
      end
      assign nx_insn[64*i +: 64] = nx_mask[i] ? {hi, win_words[32*i +: 32]} : 64'h0;
      assign nx_pc[PCW*i +: PCW] = fetch_pc + PCW'(4 * i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_pc  <= RESET_PC[PCW-1:0];
         grp_valid <= 1'b0;
         grp_mask  <= '0;
         grp_is64  <= '0;
         grp_insn  <= '0;
         grp_pc    <= '0;
         grp_cls   <= '0;
      end else if (redirect) begin
         fetch_pc  <= redirect_pc;
         grp_valid <= 1'b0;
      end else if (take) begin
         fetch_pc  <= fetch_pc + PCW'({nx_used, 2'b00});
         grp_valid <= 1'b1;
         grp_mask  <= nx_mask;
         grp_is64  <= nx_is64;
         grp_insn  <= nx_insn;
         grp_pc    <= nx_pc;
         grp_cls   <= nx_cls;
      end else if (grp_ready) begin
         grp_valid <= 1'b0;
      end
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_valid && !grp_ready && !redirect |=>
         grp_valid && $stable(fetch_pc) && $stable(grp_insn) && $stable(grp_pc));

   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !grp_valid && fetch_pc == $past(redirect_pc));

   p_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_valid && $past(take) |->
         fetch_pc == grp_pc[PCW-1:0] +
            PCW'(4 * ($countones(grp_mask) + $countones(grp_is64))));

   p_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_valid |-> grp_mask[0] && (((grp_mask + 1'b1) & grp_mask) == '0));

   p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grp_valid |-> $countones(grp_is64) <= 1 &&
                    ((grp_is64 << 1) & grp_mask) == '0);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_valid || grp_ready) && !win_valid && !redirect |=>
         !grp_valid && $stable(fetch_pc));

endmodule

// File: rtl/ild_grouper.sv
module ild_grouper
   import ild_pkg::*;
#(
   parameter int          NW        = 4,
   parameter int          PCW       = 32,
   parameter logic [63:0] RESET_PC  = 64'h0,
   parameter logic [5:0]  PFX_OPC   = 6'd1,
   parameter bit          LOOKAHEAD = 1'b1,
   localparam int CW = $clog2(NW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_valid,
   input  logic [NW*32-1:0]  win_words,
   input  logic              redirect,
   input  logic [PCW-1:0]    redirect_pc,
   input  logic              grp_ready,
   output logic [PCW-1:0]    fetch_pc,
   output logic              grp_valid,
   output logic [NW-1:0]     grp_mask,
   output logic [NW-1:0]     grp_is64,
   output logic [NW*64-1:0]  grp_insn,
   output logic [NW*PCW-1:0] grp_pc,
   output logic [2*NW-1:0]   grp_cls
);
   if (NW < 2) begin : g_chk_nw
      $error("ild_grouper: window needs at least two words");
   end
   if (PCW < 3 || PCW > 64) begin : g_chk_pcw
      $error("ild_grouper: PC width out of range");
   end

   logic [NW*OPC_W-1:0] opc;
   logic [2*NW-1:0]     cls;
   logic [NW-1:0]       mask;
   logic [NW-1:0]       is64;
   logic [CW-1:0]       used;

   for (genvar i = 0; i < NW; i++) begin : g_opc
      assign opc[OPC_W*i +: OPC_W] = win_words[32*i + OPC_LSB +: OPC_W];
   end

   ild_scan #(.NW(NW), .LOOKAHEAD(LOOKAHEAD), .PFX_OPC(PFX_OPC)) u_scan (
      .opc (opc),
      .cls (cls)
   );

   // R1/R2: a suffix only ever follows a prefix, and a prefix is never the
   // word right after another prefix
   for (genvar i = 1; i < NW; i++) begin : g_chk_cls
      p_sfx_after_pfx_r2: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid |-> (cls[2*i +: 2] == CLS_SUFFIX) ==
                       (cls[2*(i-1) +: 2] == CLS_PREFIX));
   end

   ild_pick #(.NW(NW)) u_pick (
      .cls  (cls),
      .mask (mask),
      .is64 (is64),
      .used (used)
   );

   ild_stage #(.NW(NW), .PCW(PCW), .RESET_PC(RESET_PC)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_valid   (win_valid),
      .win_words   (win_words),
      .redirect    (redirect),
      .redirect_pc (redirect_pc),
      .grp_ready   (grp_ready),
      .nx_mask     (mask),
      .nx_is64     (is64),
      .nx_used     (used),
      .nx_cls      (cls),
      .fetch_pc    (fetch_pc),
      .grp_valid   (grp_valid),
      .grp_mask    (grp_mask),
      .grp_is64    (grp_is64),
      .grp_insn    (grp_insn),
      .grp_pc      (grp_pc),
      .grp_cls     (grp_cls)
   );

endmodule

// File: tb/ild_grouper_bench.sv
module ild_grouper_bench;
   localparam int          NW  = 4;
   localparam int          PCW = 32;
   localparam logic [31:0] RPC = 32'h0000_0100;

   localparam logic [31:0] S0 = 32'h7c00_0001;
   localparam logic [31:0] S1 = 32'h3800_0002;
   localparam logic [31:0] S2 = 32'h6000_0003;
   localparam logic [31:0] S3 = 32'h8000_0004;
   localparam logic [31:0] PA = 32'h0500_1111;
   localparam logic [31:0] PB = 32'h0400_2222;
   localparam logic [31:0] XA = 32'h7c00_3333;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              win_valid = 1'b0;
   logic [NW*32-1:0]  win_words = '0;
   logic              redirect = 1'b0;
   logic [PCW-1:0]    redirect_pc = '0;
   logic              grp_ready = 1'b0;
   logic [PCW-1:0]    fetch_pc;
   logic              grp_valid;
   logic [NW-1:0]     grp_mask;
   logic [NW-1:0]     grp_is64;
   logic [NW*64-1:0]  grp_insn;
   logic [NW*PCW-1:0] grp_pc;
   logic [2*NW-1:0]   grp_cls;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ild_grouper #(.NW(NW), .PCW(PCW), .RESET_PC(64'(RPC))) u_ild_grouper (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_words(win_words),
      .redirect(redirect), .redirect_pc(redirect_pc), .grp_ready(grp_ready),
      .fetch_pc(fetch_pc), .grp_valid(grp_valid), .grp_mask(grp_mask),
      .grp_is64(grp_is64), .grp_insn(grp_insn), .grp_pc(grp_pc),
      .grp_cls(grp_cls)
   );

   // ---------------- behavioural reference ----------------
   logic              m_v = 1'b0;
   logic [31:0]       m_fpc = RPC;
   logic [3:0]        m_mask = '0;
   logic [3:0]        m_is64 = '0;
   logic [255:0]      m_insn = '0;
   logic [127:0]      m_pc = '0;
   logic [7:0]        m_cls = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_v = 1'b0;
         m_fpc = RPC;
      end else if (redirect) begin
         m_v = 1'b0;
         m_fpc = redirect_pc;
      end else if (!m_v || grp_ready) begin
         if (win_valid) begin
            int used;
            bit st;
            bit stop;
            st = 1'b0;
            for (int i = 0; i < NW; i++) begin
               if (st) begin
                  m_cls[2*i +: 2] = 2'd2;
                  st = 1'b0;
               end else if (win_words[32*i + 26 +: 6] == 6'd1) begin
                  m_cls[2*i +: 2] = 2'd1;
                  st = 1'b1;
               end else begin
                  m_cls[2*i +: 2] = 2'd0;
               end
            end
            m_mask = '0; m_is64 = '0; m_insn = '0; used = 0; stop = 1'b0;
            for (int i = 0; i < NW; i++) begin
               m_pc[32*i +: 32] = m_fpc + 32'(4 * i);
               if (!stop) begin
                  if (m_cls[2*i +: 2] == 2'd0) begin
                     m_mask[i] = 1'b1;
                     m_insn[64*i +: 32] = win_words[32*i +: 32];
                     used = i + 1;
                  end else begin
                     stop = 1'b1;
                     if (i < NW - 1) begin
                        m_mask[i] = 1'b1;
                        m_is64[i] = 1'b1;
                        m_insn[64*i +: 64] = {win_words[32*(i+1) +: 32],
                                              win_words[32*i +: 32]};
                        used = i + 2;
                     end else begin
                        used = i;
                     end
                  end
               end
            end
            m_v = 1'b1;
            m_fpc = m_fpc + 32'(4 * used);
         end else begin
            m_v = 1'b0;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R6 fetch pc", 256'(fetch_pc), 256'(m_fpc));
      chk("R7 group valid", 256'(grp_valid), 256'(m_v));
      if (m_v) begin
         chk("R3 slot mask", 256'(grp_mask), 256'(m_mask));
         chk("R5 long flags", 256'(grp_is64), 256'(m_is64));
         chk("R3 slot words", grp_insn, m_insn);
         chk("R4 slot pcs", 256'(grp_pc), 256'(m_pc));
         chk("R1 word tags", 256'(grp_cls), 256'(m_cls));
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   task automatic set_win(input logic [31:0] w0, w1, w2, w3);
      win_words = {w3, w2, w1, w0};
      win_valid = 1'b1;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0]  keep_pc;
      logic [255:0] keep_insn;
      repeat (3) @(negedge clk);
      chk("R9 reset fetch pc", 256'(fetch_pc), 256'(RPC));
      chk("R9 reset valid", 256'(grp_valid), 256'(0));
      rst_n = 1'b1;
      grp_ready = 1'b1;

      // plain words only
      set_win(S0, S1, S2, S3);
      tick();
      chk("R4 last slot pc", 256'(grp_pc[127:96]), 256'(grp_pc[31:0] + 32'd12));
      chk("R3 full mask", 256'(grp_mask), 256'(4'b1111));

      // long instruction in the middle closes the group
      set_win(S0, PA, XA, S1);
      tick();
      chk("R5 close mask", 256'(grp_mask), 256'(4'b0011));
      chk("R5 close flag", 256'(grp_is64), 256'(4'b0010));

      // prefix in the last word is held back
      set_win(S0, S1, S2, PB);
      tick();
      chk("R6 trailing prefix", 256'(fetch_pc), 256'(grp_pc[31:0] + 32'd12));
      chk("R6 trailing mask", 256'(grp_mask), 256'(4'b0111));

      // prefix-opcode run alternates
      set_win(PA, PB, PA, PB);
      tick();
      chk("R2 alternating tags", 256'(grp_cls), 256'(8'h99));
      chk("R2 single long slot", 256'(grp_mask), 256'(4'b0001));

      // suffix with prefix opcode is not a prefix
      set_win(S0, PA, PB, S1);
      tick();
      chk("R1 suffix not tested", 256'(grp_cls), 256'(8'h24));
      chk("R1 long slot words", 256'(grp_insn[127:64]), 256'({PB, PA}));

      // stall holds everything
      keep_pc = fetch_pc;
      keep_insn = grp_insn;
      grp_ready = 1'b0;
      set_win(S3, S2, S1, S0);
      tick();
      tick();
      chk("R7 held valid", 256'(grp_valid), 256'(1));
      chk("R7 held pc", 256'(fetch_pc), 256'(keep_pc));
      chk("R7 held words", grp_insn, keep_insn);

      // redirect flushes even while stalled
      redirect = 1'b1;
      redirect_pc = 32'h0000_2000;
      tick();
      redirect = 1'b0;
      chk("R8 flushed", 256'(grp_valid), 256'(0));
      chk("R8 target", 256'(fetch_pc), 256'(32'h0000_2000));

      // empty window
      win_valid = 1'b0;
      grp_ready = 1'b1;
      tick();
      chk("R10 no group", 256'(grp_valid), 256'(0));
      chk("R10 pc still", 256'(fetch_pc), 256'(32'h0000_2000));

      // mixed random traffic
      for (int c = 0; c < 3000; c++) begin
         for (int i = 0; i < NW; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom % 4 == 0) w[31:26] = 6'd1;
            win_words[32*i +: 32] = w;
         end
         win_valid = ($urandom % 8) != 0;
         grp_ready = ($urandom % 4) != 0;
         redirect = ($urandom % 32) == 0;
         redirect_pc = {$urandom, 2'b00} >> 2 << 2;
         tick();
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule